// File: doc/BRIEF.md
# Clock Distributor Init Sequencer

This block brings an external clock-distribution device from power-up to a configured state. On a start pulse it holds the device in power-down for one settle interval. It then releases power-down and waits again. Next it drives a sync pulse low for one interval and waits once more. Only after these waits does it load the device's configuration registers, one 32-bit SPI frame per register, through a separate SPI port block. That port block does the bit shifting and owns the chip-enable pin, which stays inactive (high) while no transaction is requested.

Two configuration tables are held as parameters. One serves the primary reference and one serves the secondary reference. The table-select input, sampled at start, picks which table is loaded. An optional verify mode follows each write with a read-command frame and a read transaction. It compares the returned word with the table entry that was loaded, and latches a failure flag on any mismatch.

Top module: `cdi_init_seq`

## Requirements
- R1: After reset, or while idle, pd_n and sync_n are high and busy, done, verify_fail and spi_req are low.
- R2: The cycle after an accepted start, busy is high and pd_n is low. pd_n stays low for exactly WAIT_CYCLES cycles.
- R3: After pd_n rises, exactly WAIT_CYCLES cycles pass before sync_n falls. pd_n and sync_n are never both low.
- R4: sync_n stays low for exactly WAIT_CYCLES cycles. Exactly WAIT_CYCLES further cycles pass after it rises before the first spi_req.
- R5: spi_req is never raised while pd_n or sync_n is low.
- R6: NUM_REGS write frames are sent with register index ascending from 0. Each write frame is {payload[27:0], index[3:0]}, with spi_rd low.
- R7: sel_secondary sampled with an accepted start picks the table: 1 selects SEC_TABLE and 0 selects PRI_TABLE. Changes during a run have no effect.
- R8: With verify_en sampled high at start, each write is followed by a read-command frame {24'h0, index[3:0], 4'hE} with spi_rd low. A transaction with spi_rd high then follows, so 3*NUM_REGS transactions are issued. With verify_en low, exactly NUM_REGS are issued.
- R9: A read word other than {payload[27:0], index[3:0]} sets verify_fail. verify_fail holds until the next accepted start, which clears it.
- R10: done rises when the last transaction completes and holds until the next accepted start. busy and done are never both high. A start while busy is ignored.
- R11: spi_req is a one-cycle pulse. No new request is issued until spi_done has acknowledged the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, accepted only when idle |
| sel_secondary | input | 1 | Table select: 1 secondary, 0 primary |
| verify_en | input | 1 | Enable read-back compare |
| pd_n | output | 1 | Active-low power-down pin |
| sync_n | output | 1 | Active-low sync pin |
| spi_req | output | 1 | One-cycle request to the SPI port block |
| spi_rd | output | 1 | Request is a read transaction |
| spi_wdata | output | 32 | Frame to shift out |
| spi_done | input | 1 | One-cycle completion from the SPI port block |
| spi_rdata | input | 32 | Word shifted in during a read |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence completed, sticky |
| verify_fail | output | 1 | Read-back mismatch seen, sticky |

## Verification
The assertions take for granted that spi_done pulses for one cycle only while a request is outstanding, and never in the same cycle as spi_req. They also take for granted that start and the select inputs are synchronous to clk. The bench's SPI responder keeps to this. It answers each request after a fixed latency with a single-cycle spi_done. It echoes the stored payload and the pending index on reads, and it can corrupt one stored register to provoke a mismatch. Stimulus drives start as a one-cycle pulse at the falling edge. It disturbs select and start mid-run only to show that they are ignored.

// File: rtl/cdi_pkg.sv
// Package: shared types and fixed frame constants for the init sequencer.
// Assumes register indexes fit in the 4-bit address nibble of every frame.
package cdi_pkg;
    localparam int ADDR_W    = 4;
    localparam int PAYLOAD_W = 28;
    localparam int FRAME_W   = PAYLOAD_W + ADDR_W;
    localparam logic [ADDR_W-1:0] RD_CMD_NIB = 4'hE;

    typedef logic [PAYLOAD_W-1:0] payload_t;
    typedef logic [FRAME_W-1:0]   frame_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_PD_LOW, ST_PD_SETTLE, ST_SYNC_LOW, ST_SYNC_SETTLE,
        ST_WR_REQ, ST_WR_WAIT, ST_CMD_REQ, ST_CMD_WAIT, ST_RD_REQ, ST_RD_WAIT
    } seq_state_t;

    typedef enum logic [1:0] {PH_WRITE, PH_RDCMD, PH_READ} phase_t;
endpackage

// File: rtl/cdi_wait_timer.sv
// Settle timer: counts cycles since the last clear and flags the last cycle
// of a WAIT_CYCLES window. Assumes WAIT_CYCLES >= 1; saturates when idle.
module cdi_wait_timer #(
    parameter int WAIT_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic expired
);
    localparam int CNT_W = $clog2(WAIT_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count up from zero after each clear, holding at the last value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt_q <= '0;
        else if (cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q == LAST);
endmodule

// File: rtl/cdi_frame_unit.sv
// Frame unit: looks up the selected table payload for an index, forms the
// write, read-command or read frame, and compares read data with the entry.
// Assumes idx < NUM_REGS <= 14 so indexes never collide with the read nibble.
module cdi_frame_unit
    import cdi_pkg::*;
#(
    parameter int NUM_REGS = 9,
    parameter logic [NUM_REGS-1:0][PAYLOAD_W-1:0] PRI_TABLE = '0,
    parameter logic [NUM_REGS-1:0][PAYLOAD_W-1:0] SEC_TABLE = '0
) (
    input  logic              sel_sec,
    input  logic [ADDR_W-1:0] idx,
    input  phase_t            phase,
    input  frame_t            rdata,
    output frame_t            frame,
    output logic              rd,
    output logic              match
);
    payload_t pri_entry [NUM_REGS];
    payload_t sec_entry [NUM_REGS];
    payload_t entry;

    // Unpack both parameter tables into per-register entries.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_tab
        assign pri_entry[g] = PRI_TABLE[g];
        assign sec_entry[g] = SEC_TABLE[g];
    end

    // Select the payload for the current index from the chosen table.
    always_comb begin
        entry = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (idx == ADDR_W'(i))
                entry = sel_sec ? sec_entry[i] : pri_entry[i];
        end
    end

    // Form the outgoing frame for the current phase.
    always_comb begin
        rd = 1'b0;
        unique case (phase)
            PH_WRITE: frame = {entry, idx};
            PH_RDCMD: frame = {{(FRAME_W-2*ADDR_W){1'b0}}, idx, RD_CMD_NIB};
            default: begin
                frame = '0;
                rd    = 1'b1;
            end
        endcase
    end

    assign match = (rdata == {entry, idx});
endmodule

// File: rtl/cdi_seq_fsm.sv
// Sequencer control: runs the pin sequence with settle waits, then walks the
// register indexes issuing write (and optionally verify) transactions.
// Assumes spi_done arrives only while a request is outstanding.
module cdi_seq_fsm
    import cdi_pkg::*;
#(
    parameter int NUM_REGS = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              sel_secondary,
    input  logic              verify_en,
    input  logic              expired,
    input  logic              spi_done,
    input  logic              match,
    output logic              timer_clr,
    output logic              pd_n,
    output logic              sync_n,
    output logic              spi_req,
    output phase_t            phase,
    output logic [ADDR_W-1:0] idx,
    output logic              sel_q,
    output logic              busy,
    output logic              done,
    output logic              verify_fail
);
    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_REGS - 1);

    seq_state_t state_q, state_d;
    logic ver_q, done_q, fail_q;
    logic last, advance;

    assign last = (idx == LAST_IDX);

    // Next-state selection for the pin sequence and transaction walk.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:        if (start) state_d = ST_PD_LOW;
            ST_PD_LOW:      if (expired) state_d = ST_PD_SETTLE;
            ST_PD_SETTLE:   if (expired) state_d = ST_SYNC_LOW;
            ST_SYNC_LOW:    if (expired) state_d = ST_SYNC_SETTLE;
            ST_SYNC_SETTLE: if (expired) state_d = ST_WR_REQ;
            ST_WR_REQ:      state_d = ST_WR_WAIT;
            ST_WR_WAIT:
                if (spi_done)
                    state_d = ver_q ? ST_CMD_REQ : (last ? ST_IDLE : ST_WR_REQ);
            ST_CMD_REQ:     state_d = ST_CMD_WAIT;
            ST_CMD_WAIT:    if (spi_done) state_d = ST_RD_REQ;
            ST_RD_REQ:      state_d = ST_RD_WAIT;
            ST_RD_WAIT:     if (spi_done) state_d = last ? ST_IDLE : ST_WR_REQ;
            default:        state_d = ST_IDLE;
        endcase
    end

    assign advance = spi_done && !last &&
                     ((state_q == ST_WR_WAIT && !ver_q) || state_q == ST_RD_WAIT);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture run options and track the register index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx   <= '0;
            sel_q <= 1'b0;
            ver_q <= 1'b0;
        end else if (state_q == ST_IDLE && start) begin
            idx   <= '0;
            sel_q <= sel_secondary;
            ver_q <= verify_en;
        end else if (advance) begin
            idx <= idx + 1'b1;
        end
    end

    // Sticky completion and mismatch flags, cleared by an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
        end else if (state_q == ST_IDLE && start) begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            if (state_q != ST_IDLE && state_d == ST_IDLE) done_q <= 1'b1;
            if (state_q == ST_RD_WAIT && spi_done && !match) fail_q <= 1'b1;
        end
    end

    // Output decode from the registered state.
    always_comb begin
        unique case (state_q)
            ST_CMD_REQ, ST_CMD_WAIT: phase = PH_RDCMD;
            ST_RD_REQ, ST_RD_WAIT:   phase = PH_READ;
            default:                 phase = PH_WRITE;
        endcase
    end

    assign timer_clr   = (state_d != state_q);
    assign pd_n        = (state_q != ST_PD_LOW);
    assign sync_n      = (state_q != ST_SYNC_LOW);
    assign spi_req     = (state_q == ST_WR_REQ) || (state_q == ST_CMD_REQ) ||
                         (state_q == ST_RD_REQ);
    assign busy        = (state_q != ST_IDLE);
    assign done        = done_q;
    assign verify_fail = fail_q;
endmodule

// File: rtl/cdi_init_seq.sv
// Top: clock-distributor init sequencer. Drives power-down and sync pins,
// then loads one of two parameter tables through an external SPI port block.
// Assumes the port block owns chip enable and answers each spi_req once.
module cdi_init_seq
    import cdi_pkg::*;
#(
    parameter int WAIT_CYCLES = 1000,
    parameter int NUM_REGS    = 9,
    parameter logic [NUM_REGS-1:0][PAYLOAD_W-1:0] PRI_TABLE = {
        28'h0910_020, 28'h0240_000, 28'h1000_200, 28'h0009_d14, 28'h0154_000,
        28'h0154_010, 28'h0154_020, 28'h0154_030, 28'h0154_040},
    parameter logic [NUM_REGS-1:0][PAYLOAD_W-1:0] SEC_TABLE = {
        28'h0910_0a0, 28'h0240_000, 28'h0100_000, 28'h0001_9b3, 28'h1545_002,
        28'h1545_012, 28'h1545_022, 28'h1545_032, 28'h1545_042}
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        sel_secondary,
    input  logic        verify_en,
    output logic        pd_n,
    output logic        sync_n,
    output logic        spi_req,
    output logic        spi_rd,
    output logic [31:0] spi_wdata,
    input  logic        spi_done,
    input  logic [31:0] spi_rdata,
    output logic        busy,
    output logic        done,
    output logic        verify_fail
);
    logic              timer_clr, expired, match, sel_q;
    logic [ADDR_W-1:0] idx;
    phase_t            phase;

    cdi_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(timer_clr), .expired(expired)
    );

    cdi_seq_fsm #(.NUM_REGS(NUM_REGS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .sel_secondary(sel_secondary),
        .verify_en(verify_en), .expired(expired), .spi_done(spi_done),
        .match(match), .timer_clr(timer_clr), .pd_n(pd_n), .sync_n(sync_n),
        .spi_req(spi_req), .phase(phase), .idx(idx), .sel_q(sel_q),
        .busy(busy), .done(done), .verify_fail(verify_fail)
    );

    cdi_frame_unit #(
        .NUM_REGS(NUM_REGS), .PRI_TABLE(PRI_TABLE), .SEC_TABLE(SEC_TABLE)
    ) u_frame (
        .sel_sec(sel_q), .idx(idx), .phase(phase), .rdata(spi_rdata),
        .frame(spi_wdata), .rd(spi_rd), .match(match)
    );
endmodule

// File: rtl/cdi_init_seq_chk.sv
// Checker: temporal properties of the init sequencer's ports, bound to the top.
// Assumes spi_done only answers an outstanding request.
module cdi_init_seq_chk #(
    parameter int WAIT_CYCLES = 1000
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic pd_n,
    input logic sync_n,
    input logic spi_req,
    input logic spi_done,
    input logic busy,
    input logic done,
    input logic verify_fail
);
    int   pd_cnt, sync_cnt;
    logic outst;

    // Length of the current low stretch on each pin so far.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_cnt   <= 0;
            sync_cnt <= 0;
        end else begin
            pd_cnt   <= pd_n   ? 0 : pd_cnt + 1;
            sync_cnt <= sync_n ? 0 : sync_cnt + 1;
        end
    end

    // Whether a request is waiting for its acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)        outst <= 1'b0;
        else if (spi_req)  outst <= 1'b1;
        else if (spi_done) outst <= 1'b0;
    end

    p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (pd_n && sync_n && !spi_req));
    p_pd_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |-> (pd_cnt < WAIT_CYCLES));
    p_pins_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!pd_n && !sync_n));
    p_sync_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_n |-> (sync_cnt < WAIT_CYCLES));
    p_no_spi_in_pins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pd_n || !sync_n) |-> !spi_req);
    p_fail_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (verify_fail && !(start && !busy)) |=> verify_fail);
    p_start_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done && !verify_fail));
    p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
    p_busy_done_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    p_req_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        spi_req |=> !spi_req);
    p_one_outstanding_r11: assert property (@(posedge clk) disable iff (!rst_n)
        spi_req |-> !outst);
endmodule

bind cdi_init_seq cdi_init_seq_chk #(.WAIT_CYCLES(WAIT_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .pd_n(pd_n), .sync_n(sync_n),
    .spi_req(spi_req), .spi_done(spi_done), .busy(busy), .done(done),
    .verify_fail(verify_fail)
);

// File: tb/cdi_init_seq_test.sv
module cdi_init_seq_test;
    localparam int W   = 6;
    localparam int NR  = 9;
    localparam int LAT = 3;
    localparam logic [NR-1:0][27:0] TB_PRI = {
        28'h1111_118, 28'h2222_227, 28'h3333_336, 28'h4444_445, 28'h5555_554,
        28'h6666_663, 28'h7777_772, 28'h8888_881, 28'h9999_990};
    localparam logic [NR-1:0][27:0] TB_SEC = {
        28'hA0A0_A08, 28'hB0B0_B07, 28'hC0C0_C06, 28'hD0D0_D05, 28'hE0E0_E04,
        28'hF0F0_F03, 28'h0A0A_0A2, 28'h0B0B_0B1, 28'h0C0C_0C0};
    // Vector: [5] sel_secondary, [4] verify_en, [3:0] corrupted index (F = none)
    localparam logic [5:0] VECS [0:5] = '{
        6'b00_1111, 6'b10_1111, 6'b01_1111, 6'b11_0011, 6'b01_1000, 6'b11_0000};

    logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic        sel_secondary = 1'b0, verify_en = 1'b0;
    logic        pd_n, sync_n, spi_req, spi_rd, busy, done, verify_fail;
    logic [31:0] spi_wdata, spi_rdata = '0;
    logic        spi_done = 1'b0;

    int   checks = 0, fails = 0;
    int   n_tx = 0, n_wr = 0, n_cmd = 0;
    int   corrupt_idx = 15;
    logic [31:0] wlog [0:15];
    logic [31:0] clog [0:15];
    logic [27:0] dev_reg [0:15];
    logic [3:0]  pend = '0;

    always #2.5 clk = ~clk;

    cdi_init_seq #(.WAIT_CYCLES(W), .NUM_REGS(NR), .PRI_TABLE(TB_PRI),
                   .SEC_TABLE(TB_SEC)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .sel_secondary(sel_secondary),
        .verify_en(verify_en), .pd_n(pd_n), .sync_n(sync_n), .spi_req(spi_req),
        .spi_rd(spi_rd), .spi_wdata(spi_wdata), .spi_done(spi_done),
        .spi_rdata(spi_rdata), .busy(busy), .done(done),
        .verify_fail(verify_fail));

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // SPI port model: answers each request after LAT cycles, acts as the device.
    initial begin
        forever begin
            @(negedge clk);
            spi_done = 1'b0;
            if (spi_req) begin
                n_tx++;
                if (spi_rd) begin
                    spi_rdata = {dev_reg[pend], pend};
                end else if (spi_wdata[3:0] == 4'hE) begin
                    pend = spi_wdata[7:4];
                    clog[n_cmd[3:0]] = spi_wdata;
                    n_cmd++;
                end else begin
                    dev_reg[spi_wdata[3:0]] = spi_wdata[31:4] ^
                        ((int'(spi_wdata[3:0]) == corrupt_idx) ? 28'h1 : 28'h0);
                    wlog[n_wr[3:0]] = spi_wdata;
                    n_wr++;
                end
                repeat (LAT - 1) @(negedge clk);
                spi_done = 1'b1;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    // One full sequence; disturb pulses start and flips select mid-run.
    task automatic run_seq(input logic sel, input logic ver, input int cor,
                           input logic disturb);
        int cyc = 0, t_pdf = -1, t_pdr = -1, t_sf = -1, t_sr = -1, t_req = -1;
        int pin_req = 0;
        logic [27:0] pl;
        n_tx = 0; n_wr = 0; n_cmd = 0; corrupt_idx = cor;
        @(negedge clk);
        sel_secondary = sel; verify_en = ver; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10 busy after start", {31'b0, busy}, 32'd1);
        check("R10 done cleared by start", {31'b0, done}, 32'd0);
        check("R9 fail cleared by start", {31'b0, verify_fail}, 32'd0);
        while (!done && cyc < 2000) begin
            if (!pd_n && t_pdf < 0) t_pdf = cyc;
            if (pd_n && t_pdf >= 0 && t_pdr < 0) t_pdr = cyc;
            if (!sync_n && t_sf < 0) t_sf = cyc;
            if (sync_n && t_sf >= 0 && t_sr < 0) t_sr = cyc;
            if (spi_req && t_req < 0) t_req = cyc;
            if (spi_req && (!pd_n || !sync_n)) pin_req++;
            if (disturb && cyc == 3) begin start = 1'b1; sel_secondary = ~sel; end
            if (disturb && cyc == 4) start = 1'b0;
            @(negedge clk);
            cyc++;
        end
        check("R2 pd low at start", t_pdf, 0);
        check("R2 pd low width", t_pdr - t_pdf, W);
        check("R3 pd high to sync fall", t_sf - t_pdr, W);
        check("R4 sync low width", t_sr - t_sf, W);
        check("R4 sync rise to first req", t_req - t_sr, W);
        check("R5 requests during pin phase", pin_req, 0);
        check("R8 transaction count", n_tx, ver ? 3 * NR : NR);
        check("R6 write frame count", n_wr, NR);
        for (int i = 0; i < NR; i++) begin
            pl = sel ? TB_SEC[i] : TB_PRI[i];
            check("R6 R7 write frame", wlog[i], {pl, 4'(i)});
            if (ver) check("R8 read command frame", clog[i], {24'h0, 4'(i), 4'hE});
        end
        check("R9 verify_fail", {31'b0, verify_fail}, {31'b0, ver && cor < NR});
        check("R10 done at end", {31'b0, done}, 32'd1);
        check("R10 busy at end", {31'b0, busy}, 32'd0);
        repeat (2) @(negedge clk);
        check("R10 done holds", {31'b0, done}, 32'd1);
        check("R9 fail holds", {31'b0, verify_fail}, {31'b0, ver && cor < NR});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 pd_n in reset", {31'b0, pd_n}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pd_n idle", {31'b0, pd_n}, 32'd1);
        check("R1 sync_n idle", {31'b0, sync_n}, 32'd1);
        check("R1 busy idle", {31'b0, busy}, 32'd0);
        check("R1 done idle", {31'b0, done}, 32'd0);
        check("R1 fail idle", {31'b0, verify_fail}, 32'd0);
        check("R1 req idle", {31'b0, spi_req}, 32'd0);

        foreach (VECS[v])
            run_seq(VECS[v][5], VECS[v][4], int'(VECS[v][3:0]), 1'b0);

        // R7 / R10: select flip and start pulse mid-run are ignored.
        run_seq(1'b0, 1'b0, 15, 1'b1);
        // R9: failing run, then a clean verified run clears the flag.
        run_seq(1'b1, 1'b1, 5, 1'b0);
        run_seq(1'b1, 1'b1, 15, 1'b0);

        // R1: reset in the middle of the power-down pulse returns to idle.
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 pd low before reset", {31'b0, pd_n}, 32'd0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 pd_n after mid reset", {31'b0, pd_n}, 32'd1);
        check("R1 busy after mid reset", {31'b0, busy}, 32'd0);
        check("R1 done after mid reset", {31'b0, done}, 32'd0);
        repeat (10) @(negedge clk);
        check("R1 stays idle without start", {31'b0, busy}, 32'd0);
        finish_up();
    end
endmodule